// File: doc/BRIEF.md
# Load/Store Offset Barrel Shifter

This block computes the shifted register offset used in a load/store address calculation. It takes a data word, a five-bit immediate shift count, a two-bit shift kind and the current carry flag, and produces the shifted word. A zero count changes meaning with the shift kind. For a left shift, zero is a plain pass-through. For the two right shifts, zero means a shift by the full word width. For a rotate, zero means a one-bit rotate through the carry flag.

The datapath is a logarithmic shifter with one stage per bit of the decoded shift count, plus a final stage for the full-width case. Left shifts reuse the right-shift network by reversing the bits on the way in and on the way out. The result is captured in an output register with a synchronous active-high reset. A parameter removes that register when the offset must be ready in the same cycle as its inputs.

Top module: `offs_shift`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `result` becomes all zeros.
- R2: With the default registered output, `result` shows the function of the inputs sampled at the previous rising edge of `clk`, and holds that value until the next edge.
- R3: `sh_kind` = 2'b00 (logical left) shifts `src_val` left by `sh_amt` and fills with zeros. A count of 0 returns `src_val` unchanged.
- R4: `sh_kind` = 2'b01 (logical right) with a nonzero count shifts right and fills with zeros.
- R5: `sh_kind` = 2'b01 with a count of 0 shifts by 32, so `result` is all zeros.
- R6: `sh_kind` = 2'b10 (arithmetic right) with a nonzero count shifts right and fills with copies of `src_val[31]`.
- R7: `sh_kind` = 2'b10 with a count of 0 makes every bit of `result` equal to `src_val[31]`.
- R8: `sh_kind` = 2'b11 (rotate right) with a nonzero count rotates the 32-bit word right by the count.
- R9: `sh_kind` = 2'b11 with a count of 0 yields `{carry_in, src_val[31:1]}`.
- R10: `carry_in` has no effect on `result` unless `sh_kind` = 2'b11 and `sh_amt` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| src_val | input | 32 | Word to be shifted |
| sh_amt | input | 5 | Immediate shift count |
| sh_kind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_in | input | 1 | Current carry flag, used only by the rotate-through-carry case |
| result | output | 32 | Shifted offset |

## Verification
The hardest case to reach is the one where the carry flag matters. It needs the rotate kind and a zero count at the same time, and it must be told apart from an ordinary one-bit rotate and from a right shift by 32. The stimulus drives that combination with both carry values and a low bit set, so the outcome differs from either neighbouring case. It then repeats the same words under the other kinds with carry high, to show the flag is ignored there. Full sweeps of every count for every kind, on words whose top bit is set and on words whose top bit is clear, reach the full-width fill stage and every intermediate stage.

// File: rtl/offs_shift_pkg.sv
package offs_shift_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/offs_amt_decode.sv
module offs_amt_decode #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [AW-1:0] amt,
  input  logic [1:0]    kind,
  input  logic          carry,
  input  logic          msb,
  output logic [AW:0]   eff_amt,
  output logic          fill,
  output logic          rot,
  output logic          rev
);
  import offs_shift_pkg::*;
  localparam logic [AW:0] FULL = (AW+1)'(W);
  localparam logic [AW:0] ONE  = (AW+1)'(1);

  logic amt_zero;
  assign amt_zero = (amt == '0);

  always_comb begin
    eff_amt = {1'b0, amt};
    fill    = 1'b0;
    rot     = 1'b0;
    rev     = 1'b0;
    unique case (shift_kind_e'(kind))
      SK_LSL: rev = 1'b1;
      SK_LSR: if (amt_zero) eff_amt = FULL;
      SK_ASR: begin
        fill = msb;
        if (amt_zero) eff_amt = FULL;
      end
      SK_ROR: begin
        if (amt_zero) begin
          eff_amt = ONE;   // one-bit shift with carry filling the top
          fill    = carry;
        end else begin
          rot = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/offs_shift_stage.sv
module offs_shift_stage #(
  parameter int W  = 32,
  parameter int SH = 1
) (
  input  logic [W-1:0] d,
  input  logic         en,
  input  logic         rot,
  input  logic         fill,
  output logic [W-1:0] q
);
  logic [W-1:0] moved;
  generate
    if (SH >= W) begin : g_full
      assign moved = rot ? d : {W{fill}};
    end else begin : g_part
      assign moved = rot ? {d[SH-1:0], d[W-1:SH]} : {{SH{fill}}, d[W-1:SH]};
    end
  endgenerate
  assign q = en ? moved : d;
endmodule

// File: rtl/offs_shift_core.sv
module offs_shift_core #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0] d,
  input  logic [AW:0]  amt,
  input  logic         fill,
  input  logic         rot,
  input  logic         rev,
  output logic [W-1:0] q
);
  localparam int NST = AW + 1;

  logic [W-1:0] d_rev;
  logic [W-1:0] q_rev;
  logic [W-1:0] lvl [NST+1];

  generate
    for (genvar b = 0; b < W; b++) begin : g_rev
      assign d_rev[b] = d[W-1-b];
      assign q_rev[b] = lvl[NST][W-1-b];
    end
  endgenerate

  assign lvl[0] = rev ? d_rev : d;

  generate
    for (genvar k = 0; k < NST; k++) begin : g_st
      offs_shift_stage #(.W(W), .SH(1 << k)) u_st (
        .d    (lvl[k]),
        .en   (amt[k]),
        .rot  (rot),
        .fill (fill),
        .q    (lvl[k+1])
      );
    end
  endgenerate

  assign q = rev ? q_rev : lvl[NST];
endmodule

// File: rtl/offs_shift.sv
module offs_shift #(
  parameter int W       = 32,
  parameter int AW      = $clog2(W),
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  src_val,
  input  logic [AW-1:0] sh_amt,
  input  logic [1:0]    sh_kind,
  input  logic          carry_in,
  output logic [W-1:0]  result
);
  logic [AW:0]  eff_amt;
  logic         fill;
  logic         rot;
  logic         rev;
  logic [W-1:0] shifted;

  offs_amt_decode #(.W(W), .AW(AW)) u_dec (
    .amt     (sh_amt),
    .kind    (sh_kind),
    .carry   (carry_in),
    .msb     (src_val[W-1]),
    .eff_amt (eff_amt),
    .fill    (fill),
    .rot     (rot),
    .rev     (rev)
  );

  offs_shift_core #(.W(W), .AW(AW)) u_core (
    .d    (src_val),
    .amt  (eff_amt),
    .fill (fill),
    .rot  (rot),
    .rev  (rev),
    .q    (shifted)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) result <= '0;
        else     result <= shifted;
      end
    end else begin : g_comb
      assign result = shifted;
    end
  endgenerate
endmodule

// File: rtl/offs_shift_chk.sv
module offs_shift_chk #(
  parameter int W       = 32,
  parameter int AW      = $clog2(W),
  parameter bit OUT_REG = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  src_val,
  input logic [AW-1:0] sh_amt,
  input logic [1:0]    sh_kind,
  input logic          carry_in,
  input logic [W-1:0]  result
);
  generate
    if (OUT_REG) begin : g_chk
      // R1
      reset_clear_chk: assert property (@(posedge clk) rst |=> result == '0);
      // R3
      lsl_zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (sh_kind == 2'b00 && sh_amt == '0) |=> result == $past(src_val));
      // R5
      lsr_full_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sh_kind == 2'b01 && sh_amt == '0) |=> result == '0);
      // R7
      asr_full_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (sh_kind == 2'b10 && sh_amt == '0) |=>
          ($countones(result) == (($past(src_val[W-1])) ? W : 0)));
      // R9
      rrx_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (sh_kind == 2'b11 && sh_amt == '0) |=>
          (result[W-1] == $past(carry_in) && result[W-2:0] == $past(src_val[W-1:1])));
      // R8
      ror_popcount_chk: assert property (@(posedge clk) disable iff (rst)
        (sh_kind == 2'b11 && sh_amt != '0) |=>
          $countones(result) == $countones($past(src_val)));
    end
  endgenerate
endmodule

bind offs_shift offs_shift_chk #(.W(W), .AW(AW), .OUT_REG(OUT_REG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .src_val  (src_val),
  .sh_amt   (sh_amt),
  .sh_kind  (sh_kind),
  .carry_in (carry_in),
  .result   (result)
);

// File: tb/sim_offs_shift.sv
module sim_offs_shift;
  localparam int W = 32;
  localparam int AW = 5;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 16;
  localparam int WATCHDOG = 20000;

  // {req[3:0], val[31:0], amt[4:0], kind[1:0], carry, expected[31:0]}
  localparam logic [75:0] VEC [NV] = '{
    {4'd3,  32'h8000_0001, 5'd4,  2'b00, 1'b0, 32'h0000_0010},  // R3
    {4'd3,  32'h1234_5678, 5'd0,  2'b00, 1'b0, 32'h1234_5678},  // R3
    {4'd3,  32'h0000_00FF, 5'd31, 2'b00, 1'b0, 32'h8000_0000},  // R3
    {4'd4,  32'h8000_0000, 5'd31, 2'b01, 1'b0, 32'h0000_0001},  // R4
    {4'd4,  32'hF000_000F, 5'd4,  2'b01, 1'b0, 32'h0F00_0000},  // R4
    {4'd5,  32'hFFFF_FFFF, 5'd0,  2'b01, 1'b0, 32'h0000_0000},  // R5
    {4'd6,  32'h8000_0000, 5'd4,  2'b10, 1'b0, 32'hF800_0000},  // R6
    {4'd6,  32'h7000_0000, 5'd4,  2'b10, 1'b0, 32'h0700_0000},  // R6
    {4'd7,  32'h8000_0000, 5'd0,  2'b10, 1'b0, 32'hFFFF_FFFF},  // R7
    {4'd7,  32'h7FFF_FFFF, 5'd0,  2'b10, 1'b0, 32'h0000_0000},  // R7
    {4'd8,  32'h0000_0001, 5'd1,  2'b11, 1'b0, 32'h8000_0000},  // R8
    {4'd8,  32'h1234_5678, 5'd8,  2'b11, 1'b0, 32'h7812_3456},  // R8
    {4'd9,  32'h0000_0003, 5'd0,  2'b11, 1'b1, 32'h8000_0001},  // R9
    {4'd9,  32'h0000_0003, 5'd0,  2'b11, 1'b0, 32'h0000_0001},  // R9
    {4'd10, 32'h1234_5678, 5'd0,  2'b00, 1'b1, 32'h1234_5678},  // R10
    {4'd10, 32'hF000_000F, 5'd4,  2'b01, 1'b1, 32'h0F00_0000}   // R10
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  src_val = '0;
  logic [AW-1:0] sh_amt = '0;
  logic [1:0]    sh_kind = '0;
  logic          carry_in = 1'b0;
  logic [W-1:0]  result;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  offs_shift u0 (
    .clk(clk), .rst(rst), .src_val(src_val), .sh_amt(sh_amt),
    .sh_kind(sh_kind), .carry_in(carry_in), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] expect_of(logic [W-1:0] v, int a, logic [1:0] k, logic c);
    logic [2*W-1:0] dbl;
    case (k)
      2'b00: return v << a;
      2'b01: return (a == 0) ? '0 : (v >> a);
      2'b10: begin
        if (a == 0) return {W{v[W-1]}};
        dbl = {{W{v[W-1]}}, v} >> a;
        return dbl[W-1:0];
      end
      default: begin
        if (a == 0) return {c, v[W-1:1]};
        dbl = {v, v} >> a;
        return dbl[W-1:0];
      end
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: result=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] v, logic [AW-1:0] a, logic [1:0] k, logic c);
    @(negedge clk);
    src_val = v; sh_amt = a; sh_kind = k; carry_in = c;
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: result=%h expected=completion", result);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] prev;
    src_val = 32'hDEAD_BEEF; sh_kind = 2'b00;
    repeat (3) @(negedge clk);
    check("R1 reset", result, '0);
    rst = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][71:40], VEC[i][39:35], VEC[i][34:33], VEC[i][32]);
      check($sformatf("R%0d vec%0d", int'(VEC[i][75:72]), i), result, VEC[i][31:0]);
    end

    // R2: latency of one edge, stable between edges
    apply(32'h0000_00F0, 5'd4, 2'b01, 1'b0);
    prev = result;
    src_val = 32'hFFFF_0000; sh_amt = 5'd8;
    #(CLK_PERIOD/4);
    check("R2 hold", result, prev);
    @(negedge clk);
    check("R2 update", result, 32'h00FF_FF00);

    // Sweeps of every count and kind (R3 R4 R5 R6 R7 R8 R9 R10)
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < W; a++) begin
        for (int c = 0; c < 2; c++) begin
          apply(32'hC35A_0F81, AW'(a), 2'(k), 1'(c));
          check($sformatf("R%0d sweep k=%0d a=%0d c=%0d", 3 + k * 2, k, a, c),
                result, expect_of(32'hC35A_0F81, a, 2'(k), 1'(c)));
          apply(32'h4A3C_9E16, AW'(a), 2'(k), 1'(c));
          check($sformatf("R%0d sweep k=%0d a=%0d c=%0d", 3 + k * 2, k, a, c),
                result, expect_of(32'h4A3C_9E16, a, 2'(k), 1'(c)));
        end
      end
    end

    // R10: carry ignored for ASR by 0 and ROR nonzero
    apply(32'h8000_0002, 5'd0, 2'b10, 1'b0);
    prev = result;
    apply(32'h8000_0002, 5'd0, 2'b10, 1'b1);
    check("R10 asr carry", result, prev);
    apply(32'h0000_0002, 5'd1, 2'b11, 1'b1);
    check("R10 ror carry", result, 32'h0000_0001);

    // R1 again: reset mid-run clears
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 midrun", result, '0);
    rst = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule